// File: doc/BRIEF.md
# Single-Channel Compare Timer with PWM Output

This block is a 24-bit up-counter with two compare references, sitting behind a small word-addressed register bus. The counter advances by one on every clock while counting is enabled. It produces a pulse-width-modulated output that is high for the first part of each period and low for the rest. The end of the period is set by the low reference: on a low-reference match the counter wraps to zero.

Either compare match can latch an interrupt status flag, and each match has its own enable. The flag sits inside the control word and drives the interrupt line through a global enable. Software clears the flag by writing a one to that bit position. Software can also:

- load the counter directly;
- hold the counter at zero through a reset bit;
- select a single-shot mode, in which the enable bit drops at the end of the first period.

Top module: `pwm_timer`

## Requirements
- R1: After reset every register reads zero, the PWM output is low and the interrupt line is low.
- R2: The registers sit at byte offsets 0x0 (counter), 0x4 (high reference), 0x8 (low reference) and 0xC (control). Reference registers keep 24 bits and read back with the upper 8 bits zero. A write to any other address changes nothing.
- R3: While control bit 0 (enable) is 1 and control bit 7 (counter reset) is 0, the counter rises by one per clock. Once bit 0 is 0, which includes after a write of all zeros to control, the counter holds its value.
- R4: When the counter is running and equals the low reference, its next value is 0.
- R5: A write to offset 0x0 loads the counter with the low 24 data bits on the next clock, taking priority over counting.
- R6: While control bit 7 is 1, the counter is forced to 0, even against a counter write.
- R7: The PWM output equals control bit 3 (output enable) AND (counter < high reference).
- R8: A running high-reference match with control bit 10 set, or a running low-reference match with control bit 11 set, makes status bit 6 of the control register read 1 from the next cycle.
- R9: A control write with data bit 6 = 1 clears the status flag, unless a match of R8 occurs in the same cycle, in which case the flag stays 1. A control write with bit 6 = 0 leaves the flag unchanged.
- R10: The interrupt output equals status AND control bit 5 (global interrupt enable).
- R11: With control bit 4 (single-shot) set, a running low-reference match clears control bit 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, counter steps, wraps and status changes all take effect at the first rising edge after the stimulus. Read data, the PWM level and the interrupt line follow the register state combinationally, in the same cycle.

The bench drives each stimulus at a falling edge and compares all three outputs 1 ns later against a behavioural model. The model is advanced once per rising edge, so each comparison sees exactly the state produced by the preceding edge. A match is therefore seen on the status bit and the interrupt line one cycle after the counter shows the matching value.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   // Byte offsets of the word registers
   localparam int unsigned OFS_CNT  = 'h0;
   localparam int unsigned OFS_HREF = 'h4;
   localparam int unsigned OFS_LREF = 'h8;
   localparam int unsigned OFS_CTRL = 'hC;

   // Control word bit positions
   localparam int unsigned B_EN  = 0;
   localparam int unsigned B_OE  = 3;
   localparam int unsigned B_ONE = 4;
   localparam int unsigned B_IE  = 5;
   localparam int unsigned B_SR  = 6;
   localparam int unsigned B_RST = 7;
   localparam int unsigned B_HIE = 10;
   localparam int unsigned B_LIE = 11;
   localparam int unsigned CTRL_MSB = 11;

   typedef struct packed {
      logic lo_ie;
      logic hi_ie;
      logic zero;
      logic glob_ie;
      logic single;
      logic out_en;
      logic run_en;
   } ctrl_t;
endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
   import pwmt_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              match_hi,
   input  logic              match_lo,
   output logic [DATA_W-1:0] rdata,
   output ctrl_t             ctrl,
   output logic              status,
   output logic [CNT_W-1:0]  ref_hi,
   output logic [CNT_W-1:0]  ref_lo,
   output logic              cnt_wr
);
   localparam int NREF = 2;

   logic [CNT_W-1:0] ref_q [NREF];
   logic             ctrl_wr;
   logic             set_evt;
   logic [DATA_W-1:0] ctrl_rd;
   logic              unused_bits;

   assign unused_bits = ^{addr, wdata};
   assign cnt_wr  = wr && (addr == ADDR_W'(OFS_CNT));
   assign ctrl_wr = wr && (addr == ADDR_W'(OFS_CTRL));
   assign set_evt = (match_hi && ctrl.hi_ie) || (match_lo && ctrl.lo_ie);

   // Reference registers: index 0 high, index 1 low
   for (genvar g = 0; g < NREF; g++) begin : g_ref
      localparam int unsigned OFS = (g == 0) ? OFS_HREF : OFS_LREF;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ref_q[g] <= '0;
         else if (wr && addr == ADDR_W'(OFS))
            ref_q[g] <= wdata[CNT_W-1:0];
      end
   end
   assign ref_hi = ref_q[0];
   assign ref_lo = ref_q[1];

   // Control fields; single-shot drops the enable at period end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (ctrl_wr) begin
         ctrl.run_en  <= wdata[B_EN];
         ctrl.out_en  <= wdata[B_OE];
         ctrl.single  <= wdata[B_ONE];
         ctrl.glob_ie <= wdata[B_IE];
         ctrl.zero    <= wdata[B_RST];
         ctrl.hi_ie   <= wdata[B_HIE];
         ctrl.lo_ie   <= wdata[B_LIE];
      end else if (ctrl.single && match_lo) begin
         ctrl.run_en <= 1'b0;
      end
   end

   // Status flag: a new match outranks the write-one clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status <= 1'b0;
      else if (set_evt)
         status <= 1'b1;
      else if (ctrl_wr && wdata[B_SR])
         status <= 1'b0;
   end

   always_comb begin
      ctrl_rd         = '0;
      ctrl_rd[B_EN]   = ctrl.run_en;
      ctrl_rd[B_OE]   = ctrl.out_en;
      ctrl_rd[B_ONE]  = ctrl.single;
      ctrl_rd[B_IE]   = ctrl.glob_ie;
      ctrl_rd[B_SR]   = status;
      ctrl_rd[B_RST]  = ctrl.zero;
      ctrl_rd[B_HIE]  = ctrl.hi_ie;
      ctrl_rd[B_LIE]  = ctrl.lo_ie;
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFS_CNT))
         rdata = DATA_W'(cnt);
      else if (addr == ADDR_W'(OFS_HREF))
         rdata = DATA_W'(ref_q[0]);
      else if (addr == ADDR_W'(OFS_LREF))
         rdata = DATA_W'(ref_q[1]);
      else if (addr == ADDR_W'(OFS_CTRL))
         rdata = ctrl_rd;
   end

   p_status_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> status);
   p_status_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wdata[B_SR] && !set_evt) |=> !status);
   p_single_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.single && match_lo && !ctrl_wr) |=> !ctrl.run_en);
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold_zero,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] ref_hi,
   input  logic [CNT_W-1:0] ref_lo,
   output logic [CNT_W-1:0] cnt,
   output logic             match_hi,
   output logic             match_lo
);
   localparam int NREF = 2;

   logic [CNT_W-1:0] refs  [NREF];
   logic [NREF-1:0]  match;

   assign refs[0] = ref_hi;
   assign refs[1] = ref_lo;

   for (genvar g = 0; g < NREF; g++) begin : g_cmp
      assign match[g] = run && (cnt == refs[g]);
   end
   assign match_hi = match[0];
   assign match_lo = match[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (hold_zero)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (run)
         cnt <= match_lo ? '0 : cnt + 1'b1;
   end

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !hold_zero && !load && !match_lo) |=> (cnt == $past(cnt) + 1'b1));
   p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !hold_zero && !load) |=> $stable(cnt));
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (match_lo && !hold_zero && !load) |=> (cnt == '0));
   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !hold_zero) |=> (cnt == $past(load_val)));
   p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_zero |=> (cnt == '0));
endmodule

// File: rtl/pwmt_out.sv
module pwmt_out #(
   parameter int CNT_W   = 24,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             out_en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] ref_hi,
   output logic             pwm
);
   logic level;

   assign level = out_en && (cnt < ref_hi);

   if (REG_OUT) begin : g_reg
      logic pwm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_q <= 1'b0;
         else        pwm_q <= level;
      end
      assign pwm = pwm_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign pwm = level;
   end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
   import pwmt_pkg::*;
#(
   parameter int CNT_W   = 24,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out,
   output logic              irq
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("pwm_timer: CNT_W must lie in 2..DATA_W");
   end
   if (DATA_W <= CTRL_MSB) begin : g_bad_data
      $error("pwm_timer: DATA_W too narrow for the control word");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("pwm_timer: ADDR_W must cover offset 0xC");
   end

   ctrl_t            ctrl;
   logic             status;
   logic [CNT_W-1:0] cnt, ref_hi, ref_lo;
   logic             match_hi, match_lo, cnt_wr, run;

   assign run = ctrl.run_en && !ctrl.zero;

   pwmt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .cnt(cnt), .match_hi(match_hi), .match_lo(match_lo), .rdata(bus_rdata),
      .ctrl(ctrl), .status(status), .ref_hi(ref_hi), .ref_lo(ref_lo),
      .cnt_wr(cnt_wr)
   );

   pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .hold_zero(ctrl.zero),
      .load(cnt_wr), .load_val(bus_wdata[CNT_W-1:0]), .ref_hi(ref_hi),
      .ref_lo(ref_lo), .cnt(cnt), .match_hi(match_hi), .match_lo(match_lo)
   );

   pwmt_out #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_out (
      .clk(clk), .rst_n(rst_n), .out_en(ctrl.out_en), .cnt(cnt),
      .ref_hi(ref_hi), .pwm(pwm_out)
   );

   assign irq = status && ctrl.glob_ie;

   p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!status || !ctrl.glob_ie) |-> !irq);
endmodule

// File: tb/tb_pwm_timer.sv
`timescale 1ns/1ps
module tb_pwm_timer;
   localparam int CW = 24;
   localparam logic [31:0] CMASK = 32'h00FF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        pwm, irq;

   pwm_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm), .irq(irq)
   );

   always #10 clk = ~clk;

   int vectors = 0;
   int misses  = 0;
   int cycles  = 0;
   bit done    = 0;

   // Behavioural model state
   logic [CW-1:0] m_cnt = '0, m_hi = '0, m_lo = '0;
   bit m_en, m_oe, m_one, m_ie, m_rst, m_hie, m_lie, m_sr;

   localparam int EN = 1, OE = 8, ONE = 16, IE = 32, SR = 64, RST = 128,
                  HIE = 1024, LIE = 2048;

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      case (a)
         4'h0: return {8'h0, m_cnt};
         4'h4: return {8'h0, m_hi};
         4'h8: return {8'h0, m_lo};
         4'hC: return 32'(m_en) | (32'(m_oe) << 3) | (32'(m_one) << 4) |
                      (32'(m_ie) << 5) | (32'(m_sr) << 6) | (32'(m_rst) << 7) |
                      (32'(m_hie) << 10) | (32'(m_lie) << 11);
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         misses++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic step(input bit w, input logic [3:0] a, input logic [31:0] d,
                       input string tag);
      bit run, mhi, mlo, set;
      logic [CW-1:0] n_cnt;
      @(negedge clk);
      wr = w; addr = a; wdata = d;
      #1;
      chk(tag, "rdata", rdata, exp_read(a));
      chk(tag, "pwm (R7)", 32'(pwm), 32'(m_oe && (m_cnt < m_hi)));
      chk(tag, "irq (R10)", 32'(irq), 32'(m_sr && m_ie));
      run = m_en && !m_rst;
      mhi = run && (m_cnt == m_hi);
      mlo = run && (m_cnt == m_lo);
      set = (mhi && m_hie) || (mlo && m_lie);
      if (m_rst)                  n_cnt = '0;
      else if (w && a == 4'h0)    n_cnt = d[CW-1:0];
      else if (run)               n_cnt = mlo ? '0 : m_cnt + 1'b1;
      else                        n_cnt = m_cnt;
      @(posedge clk);
      m_cnt = n_cnt;
      if (set) m_sr = 1;
      else if (w && a == 4'hC && d[6]) m_sr = 0;
      if (w && a == 4'h4) m_hi = d[CW-1:0];
      if (w && a == 4'h8) m_lo = d[CW-1:0];
      if (w && a == 4'hC) begin
         m_en = d[0]; m_oe = d[3]; m_one = d[4]; m_ie = d[5];
         m_rst = d[7]; m_hie = d[10]; m_lie = d[11];
      end else if (m_one && mlo) begin
         m_en = 0;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         misses++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: reset state on every register
      step(0, 4'h0, 0, "R1");
      step(0, 4'h4, 0, "R1");
      step(0, 4'h8, 0, "R1");
      step(0, 4'hC, 0, "R1");
      // R2: map, 24-bit masking, unmapped address ignored
      step(1, 4'h4, 32'hFFFF_FFFF, "R2");
      step(0, 4'h4, 0, "R2");
      step(1, 4'h4, 6, "R2");
      step(1, 4'h8, 10, "R2");
      step(1, 4'h1, 32'h55, "R2");
      step(0, 4'h4, 0, "R2");
      step(0, 4'h8, 0, "R2");
      // R3 R4 R7 R8 R10: continuous run with both match interrupts
      step(1, 4'hC, EN | OE | IE | HIE | LIE, "R3");
      for (int i = 0; i < 30; i++)
         step(0, (i % 3 == 0) ? 4'hC : 4'h0, 0, (i % 2) ? "R4" : "R8");
      // R9: clear with bit 6, then a write without it
      step(1, 4'hC, EN | OE | IE | HIE | LIE | SR, "R9");
      step(0, 4'hC, 0, "R9");
      for (int i = 0; i < 14; i++)
         step((i % 4) == 1, 4'hC, EN | OE | IE | LIE | ((i % 8) == 1 ? SR : 0), "R9");
      // R10: status set but global enable off
      step(1, 4'hC, EN | OE | HIE, "R10");
      for (int i = 0; i < 12; i++) step(0, 4'hC, 0, "R10");
      // R5: counter load while running
      step(1, 4'h0, 3, "R5");
      step(0, 4'h0, 0, "R5");
      step(1, 4'h0, 32'hFF00_0001, "R5");
      for (int i = 0; i < 4; i++) step(0, 4'h0, 0, "R5");
      // R6: counter-reset bit, also against a counter write
      step(1, 4'hC, EN | OE | RST, "R6");
      step(1, 4'h0, 7, "R6");
      for (int i = 0; i < 3; i++) step(0, 4'h0, 0, "R6");
      step(1, 4'hC, EN | OE, "R6");
      for (int i = 0; i < 4; i++) step(0, 4'h0, 0, "R6");
      // R7: high reference beyond low reference keeps output high
      step(1, 4'h4, 12, "R7");
      step(1, 4'h8, 8, "R7");
      for (int i = 0; i < 20; i++) step(0, 4'h0, 0, "R7");
      // R11: single-shot period
      step(1, 4'h8, 4, "R11");
      step(1, 4'h0, 0, "R11");
      step(1, 4'hC, EN | ONE | OE | IE | LIE | SR, "R11");
      for (int i = 0; i < 12; i++) step(0, (i % 2) ? 4'hC : 4'h0, 0, "R11");
      // R3: restart then stop with an all-zero control write
      step(1, 4'hC, EN, "R3");
      for (int i = 0; i < 3; i++) step(0, 4'h0, 0, "R3");
      step(1, 4'hC, 0, "R3");
      for (int i = 0; i < 5; i++) step(0, 4'h0, 0, "R3");
      finish_run();
   end
endmodule